// File: doc/BRIEF.md
# Proportional-Integral Drive Controller

This block turns a measured field sample into a drive sample. It subtracts the measurement from a setpoint and clamps the error to the signed sample range. A feedback switch then passes or blocks the error. The result is multiplied by a proportional gain. That scaled error feeds two paths. The first is a direct path weighted by one half. The second is an integrator weighted by a second gain, and it takes a step only on every other clock. The two paths are added to a feed-forward sample and a test excitation sample. The sum is clamped again and becomes the drive output.

The proportional gain comes before the split, so it scales both paths. The integrator's effective gain is therefore the product of the two gains. A shift parameter widens the integrator accumulator and divides its contribution by a power of two, which sets the usable range of the integral gain. Feedback can be removed in two ways: clear the feedback switch, or set the proportional gain to zero.

The integrator's pacing is a four-state machine. IS_CLEAR is entered at reset and on a clear request, and holds the accumulator at zero. IS_SKIP is the clock on which no step is taken. IS_STEP is the clock on which the accumulator takes a step. IS_HOLD is used while feedback is disabled. Transitions: a clear request goes to IS_CLEAR from any state. Otherwise feedback disabled goes to IS_HOLD from any state. Otherwise IS_CLEAR→IS_SKIP, IS_HOLD→IS_SKIP, IS_SKIP→IS_STEP and IS_STEP→IS_SKIP.

Top module: `pi_drive_ctrl`

## Requirements
- R1: The error is setpoint minus field, clamped to [-32768, 32767] for the default 16-bit samples; it never wraps.
- R2: With `fb_en` low, or with `kp` = 0, neither the setpoint nor the field has any effect on the direct path, and the drive equals the feed-forward plus excitation plus the held integral term.
- R3: The direct-path term is floor(floor(error × kp / 65536) / 2), with `kp` an unsigned 16-bit fraction (0x8000 = one half).
- R4: On each IS_STEP clock the accumulator adds floor(scaled × ki / 65536), where scaled = floor(error × kp / 65536) and `ki` is an unsigned 16-bit fraction. The integral term is the accumulator shifted right by SHIFT (default 5). Steps occur on alternate clocks, so a constant input raises the integral term by 256 over 64 clocks when scaled = 512 and ki = 0x8000.
- R5: The accumulator (DW+SHIFT bits) clamps at its signed full-scale limits and does not wrap.
- R6: While `fb_en` is low, the accumulator keeps its value.
- R7: A high `int_clr` on a clock edge sets the accumulator to zero.
- R8: The drive is the clamped sum of the direct term, the integral term, `ff_in` and `exc_in`. A change on `exc_in` or `ff_in` reaches `drive` after exactly one clock.
- R9: A setpoint change reaches `drive` after exactly three clocks. The drive is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setpoint | input | DW | Signed target sample |
| field | input | DW | Signed measured sample |
| fb_en | input | 1 | Feedback switch; low blocks the error and holds the integrator |
| kp | input | GW | Unsigned fractional proportional gain |
| ki | input | GW | Unsigned fractional integral gain |
| int_clr | input | 1 | Clears the integrator accumulator |
| ff_in | input | DW | Signed feed-forward sample |
| exc_in | input | DW | Signed test excitation sample |
| drive | output | DW | Signed clamped drive sample |

## Verification
The case that is hardest to reach from the ports is a saturated integrator. The accumulator is five bits wider than the output, so once the integral term is full scale the output clamp hides whether the accumulator clamped or wrapped. The stimulus drives the error to full scale with both gains at maximum. It then offsets the feed-forward to the opposite full scale, so a wrapped accumulator would show up as a sign flip on the drive. After that it reverses the error and walks the accumulator all the way to the opposite limit.

// File: rtl/pi_ctrl_pkg.sv
package pi_ctrl_pkg;

    // Integrator pacing states
    typedef enum logic [1:0] {
        IS_CLEAR = 2'd0,
        IS_SKIP  = 2'd1,
        IS_STEP  = 2'd2,
        IS_HOLD  = 2'd3
    } integ_state_t;

endpackage

// File: rtl/pi_err_stage.sv
module pi_err_stage #(
    parameter int DW = 16,
    parameter int GW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] setpoint,
    input  logic signed [DW-1:0] field,
    input  logic                 fb_en,
    input  logic        [GW-1:0] kp,
    output logic signed [DW-1:0] scaled_q
);
    localparam int PW = DW + GW + 1;
    localparam logic signed [DW:0] HI = {2'b00, {(DW-1){1'b1}}};
    localparam logic signed [DW:0] LO = {2'b11, {(DW-1){1'b0}}};

    logic signed [DW:0]   diff;
    logic signed [DW-1:0] err_d;
    logic signed [DW-1:0] err_q;
    logic signed [GW:0]   kp_s;
    logic signed [PW-1:0] prod;

    always_comb begin
        diff = {setpoint[DW-1], setpoint} - {field[DW-1], field};
        if (diff > HI)
            err_d = HI[DW-1:0];
        else if (diff < LO)
            err_d = LO[DW-1:0];
        else
            err_d = diff[DW-1:0];
        if (!fb_en)
            err_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= '0;
        else
            err_q <= err_d;
    end

    always_comb begin
        kp_s = $signed({1'b0, kp});
        prod = err_q * kp_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            scaled_q <= '0;
        else
            scaled_q <= prod[GW+DW-1:GW];
    end

    // R2
    fb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fb_en |=> (err_q == '0));

    // R3
    kp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kp == '0) |=> (scaled_q == '0));

endmodule

// File: rtl/pi_integ_stage.sv
module pi_integ_stage
    import pi_ctrl_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int SHIFT = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] scaled,
    input  logic        [GW-1:0] ki,
    input  logic                 fb_en,
    input  logic                 int_clr,
    output logic signed [DW-1:0] integ_term
);
    localparam int IW = DW + SHIFT;
    localparam int PW = DW + GW + 1;
    localparam logic signed [IW:0] AHI = {2'b00, {(IW-1){1'b1}}};
    localparam logic signed [IW:0] ALO = {2'b11, {(IW-1){1'b0}}};

    integ_state_t         state, state_nx;
    logic signed [IW-1:0] acc;
    logic signed [GW:0]   ki_s;
    logic signed [PW-1:0] prod;
    logic signed [DW-1:0] inc;
    logic signed [IW:0]   acc_sum;
    logic signed [IW-1:0] acc_sat;

    // Next-state selection
    always_comb begin
        state_nx = state;
        if (int_clr) begin
            state_nx = IS_CLEAR;
        end else if (!fb_en) begin
            state_nx = IS_HOLD;
        end else begin
            unique case (state)
                IS_CLEAR: state_nx = IS_SKIP;
                IS_HOLD:  state_nx = IS_SKIP;
                IS_SKIP:  state_nx = IS_STEP;
                IS_STEP:  state_nx = IS_SKIP;
                default:  state_nx = IS_CLEAR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= IS_CLEAR;
        else
            state <= state_nx;
    end

    // Step arithmetic
    always_comb begin
        ki_s    = $signed({1'b0, ki});
        prod    = scaled * ki_s;
        inc     = prod[GW+DW-1:GW];
        acc_sum = {acc[IW-1], acc} + {{(IW+1-DW){inc[DW-1]}}, inc};
        if (acc_sum > AHI)
            acc_sat = AHI[IW-1:0];
        else if (acc_sum < ALO)
            acc_sat = ALO[IW-1:0];
        else
            acc_sat = acc_sum[IW-1:0];
    end

    // Output process: accumulator driven by state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (int_clr) begin
            acc <= '0;
        end else begin
            unique case (state)
                IS_CLEAR: acc <= '0;
                IS_STEP:  if (fb_en) acc <= acc_sat;
                IS_SKIP:  acc <= acc;
                IS_HOLD:  acc <= acc;
                default:  acc <= acc;
            endcase
        end
    end

    assign integ_term = acc[IW-1:SHIFT];

    // R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_clr |=> (acc == '0));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fb_en && !int_clr && state != IS_CLEAR) |=> $stable(acc));

    // R4
    skip_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IS_SKIP && !int_clr) |=> $stable(acc));

    // R4
    alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IS_STEP && fb_en && !int_clr) |=> (state == IS_SKIP));

    // R5
    no_wrap_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IS_STEP && fb_en && !int_clr && !acc[IW-1] && !inc[DW-1])
        |=> !acc[IW-1]);

    // R5
    no_wrap_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == IS_STEP && fb_en && !int_clr && acc[IW-1] && inc[DW-1])
        |=> acc[IW-1]);

endmodule

// File: rtl/pi_out_stage.sv
module pi_out_stage #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] scaled,
    input  logic signed [DW-1:0] integ_term,
    input  logic signed [DW-1:0] ff_in,
    input  logic signed [DW-1:0] exc_in,
    output logic signed [DW-1:0] drive
);
    localparam int SW = DW + 2;
    localparam logic signed [SW-1:0] OHI = {3'b000, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] OLO = {3'b111, {(DW-1){1'b0}}};

    logic signed [DW-1:0] prop;
    logic signed [SW-1:0] total;
    logic signed [DW-1:0] drive_d;

    always_comb begin
        prop  = scaled >>> 1;
        total = {{2{prop[DW-1]}}, prop}
              + {{2{integ_term[DW-1]}}, integ_term}
              + {{2{ff_in[DW-1]}}, ff_in}
              + {{2{exc_in[DW-1]}}, exc_in};
        if (total > OHI)
            drive_d = OHI[DW-1:0];
        else if (total < OLO)
            drive_d = OLO[DW-1:0];
        else
            drive_d = total[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            drive <= '0;
        else
            drive <= drive_d;
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prop[DW-1] && !integ_term[DW-1] && !ff_in[DW-1] && !exc_in[DW-1])
        |=> !drive[DW-1]);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prop[DW-1] && integ_term[DW-1] && ff_in[DW-1] && exc_in[DW-1])
        |=> drive[DW-1]);

endmodule

// File: rtl/pi_drive_ctrl.sv
module pi_drive_ctrl #(
    parameter int DW    = 16,
    parameter int GW    = 16,
    parameter int SHIFT = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] setpoint,
    input  logic signed [DW-1:0] field,
    input  logic                 fb_en,
    input  logic        [GW-1:0] kp,
    input  logic        [GW-1:0] ki,
    input  logic                 int_clr,
    input  logic signed [DW-1:0] ff_in,
    input  logic signed [DW-1:0] exc_in,
    output logic signed [DW-1:0] drive
);
    logic signed [DW-1:0] scaled;
    logic signed [DW-1:0] integ_term;

    pi_err_stage #(.DW(DW), .GW(GW)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .setpoint (setpoint),
        .field    (field),
        .fb_en    (fb_en),
        .kp       (kp),
        .scaled_q (scaled)
    );

    pi_integ_stage #(.DW(DW), .GW(GW), .SHIFT(SHIFT)) u_integ (
        .clk        (clk),
        .rst_n      (rst_n),
        .scaled     (scaled),
        .ki         (ki),
        .fb_en      (fb_en),
        .int_clr    (int_clr),
        .integ_term (integ_term)
    );

    pi_out_stage #(.DW(DW)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .scaled     (scaled),
        .integ_term (integ_term),
        .ff_in      (ff_in),
        .exc_in     (exc_in),
        .drive      (drive)
    );

    // R9
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (drive == '0));

endmodule

// File: tb/pi_drive_ctrl_tb.sv
module pi_drive_ctrl_tb;
    localparam int DW = 16;
    localparam int GW = 16;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [DW-1:0] setpoint = '0;
    logic signed [DW-1:0] field = '0;
    logic                 fb_en = 1'b0;
    logic        [GW-1:0] kp = '0;
    logic        [GW-1:0] ki = '0;
    logic                 int_clr = 1'b0;
    logic signed [DW-1:0] ff_in = '0;
    logic signed [DW-1:0] exc_in = '0;
    logic signed [DW-1:0] drive;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pi_drive_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .setpoint(setpoint), .field(field),
        .fb_en(fb_en), .kp(kp), .ki(ki), .int_clr(int_clr),
        .ff_in(ff_in), .exc_in(exc_in), .drive(drive)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_integ();
        int_clr = 1'b1;
        wait_n(1);
        int_clr = 1'b0;
    endtask

    task automatic t_reset();
        wait_n(1);
        check("R9 reset", drive, 0);
        rst_n = 1'b1;
        wait_n(2);
        check("R9 idle after reset", drive, 0);
    endtask

    task automatic t_excitation();
        fb_en = 1'b0;
        exc_in = 16'sd1000;
        check("R8 exc before edge", drive, 0);
        wait_n(1);
        check("R8 exc one clock", drive, 1000);
        ff_in = 16'sd30000; exc_in = 16'sd10000;
        wait_n(1);
        check("R8 clamp high", drive, 32767);
        ff_in = -16'sd30000; exc_in = -16'sd10000;
        wait_n(1);
        check("R8 clamp low", drive, -32768);
        ff_in = 16'sd200; exc_in = -16'sd50;
        wait_n(1);
        check("R8 ff plus exc", drive, 150);
        ff_in = '0; exc_in = '0;
        wait_n(1);
    endtask

    task automatic t_proportional();
        ki = '0; kp = 16'h8000; fb_en = 1'b1;
        clear_integ();
        setpoint = 16'sd1000; field = '0;
        wait_n(6);
        check("R3 half gain", drive, 250);
        kp = 16'h4000; setpoint = 16'sd100; field = 16'sd900;
        wait_n(6);
        check("R3 negative error", drive, -100);
        // latency: change setpoint, observe at clocks 2 and 3
        setpoint = 16'sd1700;
        wait_n(2);
        check("R9 not before three clocks", drive, -100);
        wait_n(1);
        check("R9 three clocks", drive, 100);
        kp = '0;
        wait_n(4);
        check("R2 kp zero removes feedback", drive, 0);
    endtask

    task automatic t_err_saturation();
        ki = '0; kp = 16'hFFFF; fb_en = 1'b1;
        setpoint = 16'sd30000; field = -16'sd30000;
        wait_n(5);
        check("R1 error clamp high", drive, 16383);
        setpoint = -16'sd30000; field = 16'sd30000;
        wait_n(5);
        check("R1 error clamp low", drive, -16384);
        fb_en = 1'b0;
        wait_n(5);
        check("R2 switch open", drive, 0);
    endtask

    task automatic t_integrator();
        int d1, d2, d3, d4;
        kp = '0; ki = '0; fb_en = 1'b1;
        clear_integ();
        wait_n(3);
        kp = 16'h8000; ki = 16'h8000;
        setpoint = 16'sd1024; field = '0;
        wait_n(10);
        d1 = drive;
        wait_n(64);
        d2 = drive;
        check("R4 half-rate integration", d2 - d1, 256);
        // hold
        fb_en = 1'b0;
        wait_n(5);
        d3 = drive;
        wait_n(30);
        d4 = drive;
        check("R6 integrator held", d4, d3);
        check("R6 held value positive", (d3 > 0) ? 1 : 0, 1);
        fb_en = 1'b1;
        wait_n(40);
        check("R6 resumes after hold", (drive > d4 + 256) ? 1 : 0, 1);
        // clear
        kp = '0;
        clear_integ();
        wait_n(4);
        check("R7 clear zeroes integrator", drive, 0);
    endtask

    task automatic t_integ_saturation();
        kp = 16'hFFFF; ki = 16'hFFFF; fb_en = 1'b1;
        clear_integ();
        setpoint = 16'sd30000; field = -16'sd30000;
        ff_in = -16'sd32768;
        wait_n(200);
        check("R5 accumulator clamps high", drive, 16382);
        wait_n(20);
        check("R5 stays clamped high", drive, 16382);
        setpoint = -16'sd30000; field = 16'sd30000;
        ff_in = 16'sd32767;
        wait_n(300);
        check("R5 accumulator clamps low", drive, -16385);
        ff_in = '0;
        kp = '0; ki = '0;
        clear_integ();
        wait_n(4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_excitation();
        t_proportional();
        t_err_saturation();
        t_integrator();
        t_integ_saturation();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule